// File: doc/BRIEF.md
# Descriptor Ring Index Sequencer

This block tracks the position of one descriptor ring (receive or transmit) in a DMA-driven network controller. It turns a compact ring-size code from the setup record into an entry count. It holds the current entry index. From the ring base address it forms the byte address of the descriptor that the DMA engine should touch next. Each time the engine finishes an entry it pulses an advance input. The index then moves forward and returns to zero after the last entry.

One mode bit picks between small (16-bit) and large (32-bit) software structures. The mode sets how many code bits are used, how the code is decoded and how far apart the descriptors sit in memory. After setup, software may place any count into the length register directly. This replaces the decoded size, including sizes that are not powers of two.

Top module: `ring_index_seq`

## Requirements
- R1: After reset the index is 0, the length is 1, the base is 0, the mode is 16-bit, and so the descriptor address is 0.
- R2: In 16-bit mode (mode32_i = 0), only code bits [2:0] are used, and bit 3 is ignored. Code value n gives a length of 2^n, so 0 gives 1 and 7 gives 128.
- R3: In 32-bit mode (mode32_i = 1), all four code bits are used. Codes 0 to 9 give 2^n entries (1 to 512), and every code from 10 to 15 gives 512.
- R4: A load pulse captures the base, the mode and the decoded length, and sets the index to 0. All outputs show the new values one clock after the load edge.
- R5: The descriptor address equals the base with its low bits cleared, plus the index times the stride. In 16-bit mode the low 3 bits are cleared and the stride is 8 bytes. In 32-bit mode the low 4 bits are cleared and the stride is 16 bytes. The sum wraps modulo 2^ADDR_W.
- R6: An advance pulse raises the index by 1. When the index is already length-1, the advance sets the index to 0 instead.
- R7: With a length of 1, or a written length of 0 (which counts as 1), the index stays at 0 through any advance.
- R8: A length write replaces the length with any value from 0 to 2^LEN_W-1, effective one clock later. If the current index is not below the new effective length, the index becomes 0 in that same update.
- R9: When an advance and a length write occur in the same cycle, the advance steps and wraps against the newly written length.
- R10: A load overrides a length write and an advance in the same cycle. The advance is discarded and the length comes from the code.
- R11: In a cycle with no load, advance or length write, the index, the length and the address are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| load_i | input | 1 | Capture base, mode and length code; clear the index |
| mode32_i | input | 1 | Structure size at load: 1 = 32-bit, 0 = 16-bit |
| len_code_i | input | 4 | Encoded ring size |
| base_i | input | ADDR_W | Ring base byte address |
| adv_i | input | 1 | Step to the next entry |
| len_wr_i | input | 1 | Write the length directly |
| len_wr_val_i | input | LEN_W | Directly written length |
| idx_o | output | LEN_W | Current entry index |
| len_o | output | LEN_W | Current ring length |
| desc_addr_o | output | ADDR_W | Byte address of the current descriptor |

## Verification
Every state element is one register stage. The address is combinational from that state. So a load, advance or length write applied before a rising edge shows on all three outputs after that edge, with no further latency. The bench drives inputs just after a falling edge. Its reference model steps on the rising edge, and it compares all three outputs on the next falling edge. Each comparison therefore sees exactly the cycle the stimulus is due in, and no result is taken while signals are still changing.

// File: rtl/ring_seq_pkg.sv
package ring_seq_pkg;
    // width of the encoded ring-size field at the block edge
    localparam int CODE_W       = 4;
    // largest decoded size is 2**MAX_LOG2 entries
    localparam int MAX_LOG2     = 9;
    // descriptor spacing as a power of two, per structure size
    localparam int STRIDE16_LOG2 = 3;
    localparam int STRIDE32_LOG2 = 4;
endpackage

// File: rtl/ring_len_decode.sv
module ring_len_decode
    import ring_seq_pkg::*;
#(
    parameter int LEN_W = 10
) (
    input  logic              mode32_i,
    input  logic [CODE_W-1:0] code_i,
    output logic [LEN_W-1:0]  len_o
);
    localparam int SHIFT_W = $clog2(LEN_W);

    logic [SHIFT_W-1:0] shamt;

    always_comb begin
        if (mode32_i) begin
            if (code_i > CODE_W'(MAX_LOG2)) shamt = SHIFT_W'(MAX_LOG2);
            else                            shamt = SHIFT_W'(code_i);
        end else begin
            shamt = SHIFT_W'(code_i[2:0]);
        end
        len_o = LEN_W'(1) << shamt;
    end
endmodule

// File: rtl/ring_addr_gen.sv
module ring_addr_gen
    import ring_seq_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int LEN_W  = 10
) (
    input  logic [ADDR_W-1:0] base_i,
    input  logic              mode32_i,
    input  logic [LEN_W-1:0]  idx_i,
    output logic [ADDR_W-1:0] addr_o
);
    localparam logic [ADDR_W-1:0] MASK16 = ADDR_W'((1 << STRIDE16_LOG2) - 1);
    localparam logic [ADDR_W-1:0] MASK32 = ADDR_W'((1 << STRIDE32_LOG2) - 1);

    logic [ADDR_W-1:0] base_al;
    logic [ADDR_W-1:0] offset;

    always_comb begin
        if (mode32_i) begin
            base_al = base_i & ~MASK32;
            offset  = ADDR_W'(idx_i) << STRIDE32_LOG2;
        end else begin
            base_al = base_i & ~MASK16;
            offset  = ADDR_W'(idx_i) << STRIDE16_LOG2;
        end
        addr_o = base_al + offset;
    end
endmodule

// File: rtl/ring_index_ctr.sv
module ring_index_ctr #(
    parameter int LEN_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_i,
    input  logic             adv_i,
    input  logic [LEN_W-1:0] len_i,
    output logic [LEN_W-1:0] idx_o
);
    logic [LEN_W-1:0] idx_d, idx_q;
    logic [LEN_W-1:0] eff_len;

    always_comb begin
        eff_len = (len_i == '0) ? LEN_W'(1) : len_i;
        idx_d   = idx_q;
        if (clear_i) begin
            idx_d = '0;
        end else if (adv_i) begin
            if (idx_q >= eff_len - LEN_W'(1)) idx_d = '0;
            else                              idx_d = idx_q + LEN_W'(1);
        end else if (idx_q >= eff_len) begin
            idx_d = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) idx_q <= '0;
        else        idx_q <= idx_d;
    end

    assign idx_o = idx_q;
endmodule

// File: rtl/ring_index_seq.sv
module ring_index_seq
    import ring_seq_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int LEN_W  = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic              mode32_i,
    input  logic [3:0]        len_code_i,
    input  logic [ADDR_W-1:0] base_i,
    input  logic              adv_i,
    input  logic              len_wr_i,
    input  logic [LEN_W-1:0]  len_wr_val_i,
    output logic [LEN_W-1:0]  idx_o,
    output logic [LEN_W-1:0]  len_o,
    output logic [ADDR_W-1:0] desc_addr_o
);
    typedef struct packed {
        logic [ADDR_W-1:0] base;
        logic              mode32;
        logic [LEN_W-1:0]  len;
    } ring_state_t;

    ring_state_t      st_d, st_q;
    logic [LEN_W-1:0] dec_len;
    logic             mode32_q;

    ring_len_decode #(.LEN_W(LEN_W)) u_dec (
        .mode32_i (mode32_i),
        .code_i   (len_code_i),
        .len_o    (dec_len)
    );

    always_comb begin
        st_d = st_q;
        if (load_i) begin
            st_d.base   = base_i;
            st_d.mode32 = mode32_i;
            st_d.len    = dec_len;
        end else if (len_wr_i) begin
            st_d.len    = len_wr_val_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.base   <= '0;
            st_q.mode32 <= 1'b0;
            st_q.len    <= LEN_W'(1);
        end else begin
            st_q <= st_d;
        end
    end

    ring_index_ctr #(.LEN_W(LEN_W)) u_ctr (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (load_i),
        .adv_i   (adv_i),
        .len_i   (st_d.len),
        .idx_o   (idx_o)
    );

    ring_addr_gen #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_addr (
        .base_i   (st_q.base),
        .mode32_i (st_q.mode32),
        .idx_i    (idx_o),
        .addr_o   (desc_addr_o)
    );

    assign len_o    = st_q.len;
    assign mode32_q = st_q.mode32;
endmodule

// File: rtl/ring_index_seq_chk.sv
module ring_index_seq_chk #(
    parameter int ADDR_W = 32,
    parameter int LEN_W  = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic              load_i,
    input logic              adv_i,
    input logic              len_wr_i,
    input logic              mode32_q,
    input logic [LEN_W-1:0]  idx_o,
    input logic [LEN_W-1:0]  len_o,
    input logic [ADDR_W-1:0] desc_addr_o
);
    // R4: load clears the index
    assert_load_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (idx_o == '0));

    // R6: plain step below the last entry
    assert_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (adv_i && !load_i && !len_wr_i && (len_o > LEN_W'(1)) && (idx_o < len_o - LEN_W'(1)))
        |=> (idx_o == LEN_W'($past(idx_o) + LEN_W'(1))));

    // R6: wrap at the last entry
    assert_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (adv_i && !load_i && !len_wr_i && (len_o != '0) && (idx_o == len_o - LEN_W'(1)))
        |=> (idx_o == '0));

    // R8: index never leaves the ring
    assert_idx_in_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (len_o == '0) ? (idx_o == '0) : (idx_o < len_o));

    // R5: address alignment follows the mode
    assert_addr_align_R5: assert property (@(posedge clk) disable iff (!rst_n)
        mode32_q ? (desc_addr_o[3:0] == 4'd0) : (desc_addr_o[2:0] == 3'd0));

    // R11: idle cycle changes nothing
    assert_idle_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && !adv_i && !len_wr_i)
        |=> ($stable(idx_o) && $stable(len_o) && $stable(desc_addr_o)));
endmodule

bind ring_index_seq ring_index_seq_chk #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .load_i      (load_i),
    .adv_i       (adv_i),
    .len_wr_i    (len_wr_i),
    .mode32_q    (mode32_q),
    .idx_o       (idx_o),
    .len_o       (len_o),
    .desc_addr_o (desc_addr_o)
);

// File: tb/sim_ring_index_seq.sv
module sim_ring_index_seq;
    localparam int  ADDR_W = 32;
    localparam int  LEN_W  = 10;
    localparam time TCLK   = 10ns;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              load_i = 1'b0;
    logic              mode32_i = 1'b0;
    logic [3:0]        len_code_i = '0;
    logic [ADDR_W-1:0] base_i = '0;
    logic              adv_i = 1'b0;
    logic              len_wr_i = 1'b0;
    logic [LEN_W-1:0]  len_wr_val_i = '0;
    logic [LEN_W-1:0]  idx_o, len_o;
    logic [ADDR_W-1:0] desc_addr_o;

    int checks = 0;
    int errors = 0;
    string tag = "R1";

    // behavioural reference state
    longint m_idx = 0, m_len = 1, m_base = 0;
    bit     m_mode32 = 0;

    always #(TCLK/2) clk = ~clk;

    ring_index_seq #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u0 (
        .clk(clk), .rst_n(rst_n), .load_i(load_i), .mode32_i(mode32_i),
        .len_code_i(len_code_i), .base_i(base_i), .adv_i(adv_i),
        .len_wr_i(len_wr_i), .len_wr_val_i(len_wr_val_i),
        .idx_o(idx_o), .len_o(len_o), .desc_addr_o(desc_addr_o)
    );

    function automatic longint size_of(bit m32, int code);
        if (m32) return (code >= 10) ? 512 : (longint'(1) << code);
        return longint'(1) << (code % 8);
    endfunction

    function automatic longint exp_addr();
        longint st = m_mode32 ? 16 : 8;
        longint b  = m_base - (m_base % st);
        return (b + m_idx * st) % (longint'(1) << ADDR_W);
    endfunction

    task automatic model_edge();
        longint nl, el;
        if (load_i) begin
            m_base   = longint'(base_i);
            m_mode32 = mode32_i;
            m_len    = size_of(mode32_i, int'(len_code_i));
            m_idx    = 0;
        end else begin
            nl = len_wr_i ? longint'(len_wr_val_i) : m_len;
            el = (nl == 0) ? 1 : nl;
            if (adv_i)          m_idx = (m_idx >= el - 1) ? 0 : m_idx + 1;
            else if (m_idx >= el) m_idx = 0;
            m_len = nl;
        end
    endtask

    task automatic compare();
        checks++;
        if (longint'(idx_o) != m_idx) begin
            errors++;
            $display("FAIL %s idx actual %0d expected %0d", tag, idx_o, m_idx);
        end
        checks++;
        if (longint'(len_o) != m_len) begin
            errors++;
            $display("FAIL %s len actual %0d expected %0d", tag, len_o, m_len);
        end
        checks++;
        if (longint'(desc_addr_o) != exp_addr()) begin
            errors++;
            $display("FAIL %s addr actual %h expected %h", tag, desc_addr_o, exp_addr());
        end
    endtask

    // one clock: reference steps on the rising edge, outputs compared at the falling edge
    task automatic tick();
        @(posedge clk);
        model_edge();
        @(negedge clk);
        compare();
        load_i = 0; adv_i = 0; len_wr_i = 0;
    endtask

    task automatic do_load(bit m32, int code, longint base);
        load_i = 1; mode32_i = m32; len_code_i = 4'(code); base_i = ADDR_W'(base);
        tick();
    endtask

    task automatic do_adv(int n);
        for (int i = 0; i < n; i++) begin adv_i = 1; tick(); end
    endtask

    task automatic do_wr(int v, bit with_adv);
        len_wr_i = 1; len_wr_val_i = LEN_W'(v); adv_i = with_adv;
        tick();
    endtask

    initial begin
        #(TCLK * 200000);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        tag = "R1"; compare();

        tag = "R2"; do_load(0, 3, 64'h1000_0007); do_adv(3);
        tag = "R6"; do_adv(6);
        tag = "R2";
        for (int c = 0; c < 16; c++) begin do_load(0, c, 64'h2000_00F5); do_adv(2); end
        tag = "R3";
        for (int c = 0; c < 16; c++) begin do_load(1, c, 64'h3000_001F); do_adv(3); end
        tag = "R5"; do_load(1, 2, 64'hFFFF_FFEF); do_adv(5);
        tag = "R5"; do_load(0, 7, 64'hFFFF_FFF9); do_adv(130);
        tag = "R7"; do_load(1, 0, 64'h4000_0000); do_adv(4);
        tag = "R8"; do_load(1, 4, 64'h5000_0000); do_adv(3);
        do_wr(5, 0); do_adv(6);
        do_adv(4); do_wr(2, 0); do_adv(3);
        do_wr(1000, 0); do_adv(20);
        tag = "R7"; do_wr(0, 0); do_adv(3);
        tag = "R9"; do_wr(7, 0); do_adv(6); do_wr(7, 1); do_adv(2); do_wr(3, 1);
        tag = "R10"; do_adv(1);
        load_i = 1; mode32_i = 0; len_code_i = 4'd5; base_i = 32'h6000_0000;
        adv_i = 1; len_wr_i = 1; len_wr_val_i = 10'd3; tick();
        tag = "R11"; repeat (5) tick();
        tag = "R6";
        for (int i = 0; i < 3000; i++) begin
            int r = $urandom_range(0, 99);
            if (r < 3) begin
                load_i = 1; mode32_i = $urandom_range(0, 1) != 0;
                len_code_i = 4'($urandom_range(0, 15)); base_i = $urandom;
            end
            if (r >= 3 && r < 8) begin
                len_wr_i = 1; len_wr_val_i = LEN_W'($urandom_range(0, 40));
            end
            adv_i = ($urandom_range(0, 2) != 0);
            tick();
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule